// File: doc/BRIEF.md
# Inter-Processor Interrupt Mailbox

This block is the meeting point for interrupts that one processor sends to another in a system of `NCPU` processors. Every processor owns one 64-bit mailbox word. Any processor can write a message into any mailbox. A stored message is never queued behind an older one: it replaces whatever was already there. A word of all zeros means the mailbox is empty, so a mailbox is pending exactly when its word is non-zero.

The owner of a mailbox reads it through its own request port. A fetch returns the word and empties the mailbox in the same clock edge. A peek returns the word and leaves it in place. Each processor has an interrupt line. That line rises only when the mailbox is pending and the mailbox's programmed priority is above the processor's current mask level. A message that is masked stays stored until it is fetched.

The top byte of each stored word is the command. A per-mailbox status output sorts that byte into a command family, so that status logic can see what kind of request is waiting without reading the word.

Top module: `ipi_mailbox`

## Requirements
- R1: While `rst_n` is low at a clock edge, every mailbox is emptied and `rsp_valid` is cleared. After reset, `pending`, `irq` and `rsp_valid` are all 0 and every `group` field is 0.
- R2: When a non-zero post is addressed to a mailbox, the mailbox holds that word from the next clock edge and its `pending` bit is 1. A later post replaces the stored word, so the latest word wins.
- R3: In a message word, bits [63:56] are the command and bits [55:0] are the parameter. Each mailbox has a 3-bit `group` field. It is 0 for an empty mailbox. For a non-zero word it is set from the command: 1 for 0x01–0x07, 2 for 0x10–0x13, 3 for 0x20–0x22, 4 for 0x30–0x31, 5 for 0x40–0x42, 6 for 0xF0–0xFF, and 7 for any other value, including 0x00 with a non-zero parameter.
- R4: A fetch (`rd_req`=1, `rd_clear`=1) raises `rsp_valid` one cycle later, with `rsp_data` equal to the word held at the request edge. The mailbox is empty afterwards.
- R5: A peek (`rd_req`=1, `rd_clear`=0) returns the word in the same way and leaves the mailbox unchanged.
- R6: If a fetch and a non-zero post hit the same mailbox in the same cycle, the response carries the old word and the mailbox keeps the newly posted word.
- R7: If several sources post non-zero words to one mailbox in the same cycle, the source with the lowest index is stored. All other posts are dropped.
- R8: A post whose word is zero is ignored. It does not change the mailbox and it does not take part in the arbitration of R7.
- R9: `irq[i]` is 1 exactly when mailbox i is pending and `ipi_level[i]` > `cur_mask[i]` (both unsigned). A masked message stays pending.
- R10: `rsp_valid[i]` is 1 only in the cycle after a request from CPU i. At all other times `rsp_data` for that CPU is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| post_valid | input | NCPU | Post strobe, one bit per source CPU |
| post_target | input | NCPU*TGT_W | Target mailbox index for each source, TGT_W = clog2(NCPU) |
| post_data | input | NCPU*64 | Message word for each source |
| rd_req | input | NCPU | Read request from each CPU to its own mailbox |
| rd_clear | input | NCPU | 1 = fetch (read and clear), 0 = peek |
| ipi_level | input | NCPU*PRIO_W | Programmed interrupt priority of each mailbox |
| cur_mask | input | NCPU*PRIO_W | Current interrupt mask level of each CPU |
| rsp_valid | output | NCPU | Read response strobe |
| rsp_data | output | NCPU*64 | Read response word |
| pending | output | NCPU | Mailbox holds a non-zero word |
| irq | output | NCPU | Unmasked interrupt request |
| group | output | NCPU*3 | Command family of the stored word |

## Verification
Two situations are hard to reach from the ports. The first is a fetch and a post landing on the same mailbox at the same edge. The second is a contested post in which the lowest-index contender sends a zero word. The bench drives every non-empty subset of posters against one mailbox. It runs that sweep twice: once with source 0 sending a real word and once with it sending zero, so the winner moves to the next index. It also times a post to coincide with the owner's fetch. All 256 command bytes are swept through the family decode, and every priority level is tried against every mask level.

// File: rtl/ipi_mailbox_pkg.sv
// Package: shared widths and the command-family code for the IPI mailbox.
// Assumes messages are 64 bits with the command in the top byte.
package ipi_mailbox_pkg;
    localparam int MSG_W = 64;
    localparam int CMD_W = 8;
    localparam int GRP_W = 3;

    typedef enum logic [GRP_W-1:0] {
        GRP_EMPTY   = 3'd0,
        GRP_TLB     = 3'd1,
        GRP_CACHE   = 3'd2,
        GRP_BARRIER = 3'd3,
        GRP_SYNC    = 3'd4,
        GRP_CTRL    = 3'd5,
        GRP_CUSTOM  = 3'd6,
        GRP_RSVD    = 3'd7
    } grp_e;
endpackage

// File: rtl/ipi_post_arbiter.sv
// Module: selects the single post written into one target mailbox.
// Zero words are discarded before selection; among the remaining posts
// addressed to TARGET, the lowest source index wins.
// Assumes NCPU >= 2.
module ipi_post_arbiter
    import ipi_mailbox_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int TARGET = 0,
    parameter int TGT_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCPU-1:0]         post_valid,
    input  logic [NCPU*TGT_W-1:0]   post_target,
    input  logic [NCPU*MSG_W-1:0]   post_data,
    output logic                    wr_en,
    output logic [MSG_W-1:0]        wr_data
);
    logic [NCPU-1:0] hit;

    // Per-source qualification: valid, aimed here, and non-zero.
    always_comb begin
        for (int s = 0; s < NCPU; s++) begin
            hit[s] = post_valid[s]
                   && (post_target[s*TGT_W +: TGT_W] == TGT_W'(TARGET))
                   && (post_data[s*MSG_W +: MSG_W] != '0);
        end
    end

    // Priority pick: scanning downwards leaves the lowest hitting index.
    always_comb begin
        wr_en   = 1'b0;
        wr_data = '0;
        for (int s = NCPU - 1; s >= 0; s--) begin
            if (hit[s]) begin
                wr_en   = 1'b1;
                wr_data = post_data[s*MSG_W +: MSG_W];
            end
        end
    end

    // Source 0 posting a real word here must always be the one written.
    assert_src0_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid[0] && post_target[TGT_W-1:0] == TGT_W'(TARGET)
         && post_data[MSG_W-1:0] != '0)
        |-> (wr_en && wr_data == post_data[MSG_W-1:0]));

    // With no post aimed here there is nothing to write.
    assert_no_post_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid == '0) |-> !wr_en);
endmodule

// File: rtl/ipi_slot.sv
// Module: one 64-bit mailbox with fetch/peek response register.
// A write from the arbiter has priority over a clear from a fetch, so the
// newly posted word survives a fetch in the same cycle. The response always
// carries the word held before the edge.
module ipi_slot
    import ipi_mailbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [MSG_W-1:0] wr_data,
    input  logic             rd_req,
    input  logic             rd_clear,
    output logic [MSG_W-1:0] slot_q,
    output logic             rsp_valid,
    output logic [MSG_W-1:0] rsp_data
);
    // Mailbox word: post overwrites, fetch clears, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                  slot_q <= '0;
        else if (wr_en)              slot_q <= wr_data;
        else if (rd_req && rd_clear) slot_q <= '0;
    end

    // Read response: capture the pre-edge word for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_req;
            rsp_data  <= rd_req ? slot_q : '0;
        end
    end

    assert_post_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (slot_q == $past(wr_data)));

    assert_fetch_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_clear && !wr_en) |=> (slot_q == '0));

    assert_peek_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_clear && !wr_en) |=> $stable(slot_q));

    assert_rsp_old_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> (rsp_valid && rsp_data == $past(slot_q)));

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_req) |=> $stable(slot_q));

    assert_rsp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> (!rsp_valid && rsp_data == '0));
endmodule

// File: rtl/ipi_cmd_decode.sv
// Module: sorts a mailbox word into a command family for status.
// An all-zero word reports empty; command bytes outside every defined
// family (including 0x00 with a parameter) report reserved.
module ipi_cmd_decode
    import ipi_mailbox_pkg::*;
(
    input  logic [MSG_W-1:0] word,
    output grp_e             grp
);
    logic [CMD_W-1:0] cmd;
    assign cmd = word[MSG_W-1 -: CMD_W];

    // Range compare on the command byte.
    always_comb begin
        if (word == '0)                       grp = GRP_EMPTY;
        else if (cmd >= 8'h01 && cmd <= 8'h07) grp = GRP_TLB;
        else if (cmd >= 8'h10 && cmd <= 8'h13) grp = GRP_CACHE;
        else if (cmd >= 8'h20 && cmd <= 8'h22) grp = GRP_BARRIER;
        else if (cmd >= 8'h30 && cmd <= 8'h31) grp = GRP_SYNC;
        else if (cmd >= 8'h40 && cmd <= 8'h42) grp = GRP_CTRL;
        else if (cmd >= 8'hF0)                 grp = GRP_CUSTOM;
        else                                   grp = GRP_RSVD;
    end
endmodule

// File: rtl/ipi_mailbox.sv
// Module: top of the IPI mailbox for NCPU processors.
// One arbiter, one slot and one decoder per CPU; pending and the masked
// interrupt are derived from the stored word. Assumes NCPU >= 2.
module ipi_mailbox
    import ipi_mailbox_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter int PRIO_W = 3,
    localparam int TGT_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NCPU-1:0]         post_valid,
    input  logic [NCPU*TGT_W-1:0]   post_target,
    input  logic [NCPU*64-1:0]      post_data,
    input  logic [NCPU-1:0]         rd_req,
    input  logic [NCPU-1:0]         rd_clear,
    input  logic [NCPU*PRIO_W-1:0]  ipi_level,
    input  logic [NCPU*PRIO_W-1:0]  cur_mask,
    output logic [NCPU-1:0]         rsp_valid,
    output logic [NCPU*64-1:0]      rsp_data,
    output logic [NCPU-1:0]         pending,
    output logic [NCPU-1:0]         irq,
    output logic [NCPU*3-1:0]       group
);
    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        logic             wr_en;
        logic [MSG_W-1:0] wr_data;
        logic [MSG_W-1:0] slot_q;
        grp_e             grp;

        ipi_post_arbiter #(
            .NCPU   (NCPU),
            .TARGET (i),
            .TGT_W  (TGT_W)
        ) u_arb (
            .clk         (clk),
            .rst_n       (rst_n),
            .post_valid  (post_valid),
            .post_target (post_target),
            .post_data   (post_data),
            .wr_en       (wr_en),
            .wr_data     (wr_data)
        );

        ipi_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_en),
            .wr_data   (wr_data),
            .rd_req    (rd_req[i]),
            .rd_clear  (rd_clear[i]),
            .slot_q    (slot_q),
            .rsp_valid (rsp_valid[i]),
            .rsp_data  (rsp_data[i*MSG_W +: MSG_W])
        );

        ipi_cmd_decode u_dec (
            .word (slot_q),
            .grp  (grp)
        );

        // Status and interrupt: non-zero word is pending; raise when unmasked.
        always_comb begin
            pending[i]                = (slot_q != '0);
            group[i*GRP_W +: GRP_W]   = grp;
            irq[i]                    = pending[i]
                && (ipi_level[i*PRIO_W +: PRIO_W] > cur_mask[i*PRIO_W +: PRIO_W]);
        end

        assert_irq_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> pending[i]);

        assert_masked_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (pending[i] && !irq[i] && !rd_req[i]) |=> pending[i]);

        assert_group_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (group[i*GRP_W +: GRP_W] == 3'd0) == !pending[i]);
    end
endmodule

// File: tb/ipi_mailbox_bench.sv
// Bench: drives the mailbox from a reference model of the requirements and
// compares every output after each step.
module ipi_mailbox_bench;
    localparam int NC = 4;
    localparam int PW = 3;
    localparam int TW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [NC-1:0]     post_valid, rd_req, rd_clear, rsp_valid, pending, irq;
    logic [NC*TW-1:0]  post_target;
    logic [NC*64-1:0]  post_data, rsp_data;
    logic [NC*PW-1:0]  ipi_level, cur_mask;
    logic [NC*3-1:0]   group;

    logic          pv [NC];
    logic [TW-1:0] pt [NC];
    logic [63:0]   pd [NC];
    logic          rq [NC];
    logic          rc [NC];
    logic [PW-1:0] lv [NC];
    logic [PW-1:0] mk [NC];
    logic [63:0]   model [NC];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always_comb begin
        for (int c = 0; c < NC; c++) begin
            post_valid[c]             = pv[c];
            post_target[c*TW +: TW]   = pt[c];
            post_data[c*64 +: 64]     = pd[c];
            rd_req[c]                 = rq[c];
            rd_clear[c]               = rc[c];
            ipi_level[c*PW +: PW]     = lv[c];
            cur_mask[c*PW +: PW]      = mk[c];
        end
    end

    ipi_mailbox #(.NCPU(NC), .PRIO_W(PW)) u_ipi_mailbox (
        .clk(clk), .rst_n(rst_n),
        .post_valid(post_valid), .post_target(post_target), .post_data(post_data),
        .rd_req(rd_req), .rd_clear(rd_clear),
        .ipi_level(ipi_level), .cur_mask(cur_mask),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .pending(pending), .irq(irq), .group(group)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] grp_of(logic [63:0] w);
        logic [7:0] c = w[63:56];
        if (w == 64'd0)                 return 3'd0;
        if (c >= 8'h01 && c <= 8'h07)   return 3'd1;
        if (c >= 8'h10 && c <= 8'h13)   return 3'd2;
        if (c >= 8'h20 && c <= 8'h22)   return 3'd3;
        if (c >= 8'h30 && c <= 8'h31)   return 3'd4;
        if (c >= 8'h40 && c <= 8'h42)   return 3'd5;
        if (c >= 8'hF0)                 return 3'd6;
        return 3'd7;
    endfunction

    task automatic idle_inputs();
        for (int c = 0; c < NC; c++) begin
            pv[c] = 0; pt[c] = '0; pd[c] = '0; rq[c] = 0; rc[c] = 0;
        end
    endtask

    // Apply the staged inputs for one edge, advance the model, compare outputs.
    task automatic step(string tag);
        logic [63:0] nxt [NC];
        logic [63:0] ersp [NC];
        logic        ev [NC];
        for (int t = 0; t < NC; t++) begin
            nxt[t]  = model[t];
            ev[t]   = rq[t];
            ersp[t] = rq[t] ? model[t] : 64'd0;
            if (rq[t] && rc[t]) nxt[t] = 64'd0;
        end
        for (int t = 0; t < NC; t++) begin
            bit found = 0;
            for (int s = 0; s < NC; s++) begin
                if (!found && pv[s] && pt[s] == TW'(t) && pd[s] != 64'd0) begin
                    nxt[t] = pd[s];
                    found  = 1;
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int t = 0; t < NC; t++) model[t] = nxt[t];
        idle_inputs();
        #1;
        for (int c = 0; c < NC; c++) begin
            check({tag, " pending"}, 64'(pending[c]), 64'(model[c] != 64'd0));
            check({tag, " group R3"}, 64'(group[c*3 +: 3]), 64'(grp_of(model[c])));
            check({tag, " rsp_valid R10"}, 64'(rsp_valid[c]), 64'(ev[c]));
            check({tag, " rsp_data"}, rsp_data[c*64 +: 64], ersp[c]);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        for (int c = 0; c < NC; c++) begin lv[c] = '0; mk[c] = '0; model[c] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 pending", 64'(pending), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);
        check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        check("R1 group", 64'(group), 64'd0);

        // R2: each CPU posts to its neighbour, then overwrite mailbox 1
        for (int c = 0; c < NC; c++) begin
            pv[c] = 1; pt[c] = TW'((c + 1) % NC);
            pd[c] = {8'h01 + 8'(c), 56'h100 + 56'(c)};
        end
        step("R2 post");
        pv[3] = 1; pt[3] = 2'd1; pd[3] = {8'h41, 56'hABCDEF};
        step("R2 overwrite");

        // R5: peek everything, R4: then fetch everything
        for (int c = 0; c < NC; c++) begin rq[c] = 1; rc[c] = 0; end
        step("R5 peek");
        for (int c = 0; c < NC; c++) begin rq[c] = 1; rc[c] = 1; end
        step("R4 fetch");

        // R6: fetch and post on the same mailbox in one cycle
        pv[0] = 1; pt[0] = 2'd3; pd[0] = {8'h20, 56'h5};
        step("R6 setup");
        pv[1] = 1; pt[1] = 2'd3; pd[1] = {8'h30, 56'h6};
        rq[3] = 1; rc[3] = 1;
        step("R6 collide");

        // R7/R8: all non-empty poster subsets against mailbox 2, src0 real or zero
        for (int z = 0; z < 2; z++) begin
            for (int m = 1; m < (1 << NC); m++) begin
                for (int s = 0; s < NC; s++) begin
                    pv[s] = m[s]; pt[s] = 2'd2;
                    pd[s] = (z == 1 && s == 0) ? 64'd0
                          : {8'hF0 + 8'(s), 48'(m), 8'(z)};
                end
                step(z == 0 ? "R7 arbitrate" : "R8 zero arbitrate");
            end
        end

        // R8: zero post to a full mailbox and to an empty one
        pv[2] = 1; pt[2] = 2'd2; pd[2] = 64'd0;
        pv[1] = 1; pt[1] = 2'd0; pd[1] = 64'd0;
        step("R8 zero post");

        // R3: sweep every command byte through mailbox 0
        for (int cmd = 0; cmd < 256; cmd++) begin
            pv[1] = 1; pt[1] = 2'd0; pd[1] = {8'(cmd), 56'h1};
            step("R3 sweep");
        end

        // R9: every level against every mask with mailbox 1 pending
        pv[0] = 1; pt[0] = 2'd1; pd[0] = {8'h42, 56'h9};
        step("R9 setup");
        for (int l = 0; l < (1 << PW); l++) begin
            for (int k = 0; k < (1 << PW); k++) begin
                lv[1] = PW'(l); mk[1] = PW'(k);
                #1;
                check("R9 irq", 64'(irq[1]), 64'(l > k));
                check("R9 still pending", 64'(pending[1]), 64'd1);
            end
        end
        lv[1] = 3'd7; mk[1] = 3'd0;
        rq[1] = 1; rc[1] = 1;
        step("R9 fetch");
        check("R9 irq after fetch", 64'(irq[1]), 64'd0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule